// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block orders two IEEE-754 values, in either single or double precision, and reports the result as a 2-bit condition code. The code is merged into a fixed two-bit field of a 32-bit status word. The caller presents three things together with a one-cycle `in_valid` strobe: the instruction word, the two operand register pairs (each already fetched as 64 bits), and the current status word. One cycle later the unit returns the updated status word with `done_o` high.

The instruction selects one of two precisions and one of two NaN policies. Under the quiet policy, an unordered pair is reported through the code. Under the signalling policy, a NaN operand raises `inv_o` and the status word passes through untouched. A sub-opcode outside the compare group raises `ill_o` instead.

A two-state machine tracks the result slot:
- **ST_IDLE** moves to **ST_REPORT** when `in_valid` is high.
- **ST_REPORT** stays there when another `in_valid` arrives back to back.
- **ST_REPORT** returns to **ST_IDLE** when `in_valid` is low.

`done_o` is high exactly while the machine is in ST_REPORT.

Top module: `fcc_unit`

## Requirements
- R1: The sub-opcode is `instr[13:5]`. 0x51 is the quiet single compare, 0x52 the quiet double, 0x55 the signalling single and 0x56 the signalling double. Bits outside 18:14, 13:5 and 4:0 have no effect.
- R2: For a legal compare with no exception, `stat_out[11:10]` holds the code: 0 equal, 1 first operand less, 2 first operand greater, 3 unordered. Every other bit of `stat_out` equals `stat_in` as sampled with `in_valid`.
- R3: In a quiet compare, a NaN (exponent all ones, fraction non-zero) in either operand gives code 3 and leaves `inv_o` low.
- R4: In a signalling compare, a NaN in either operand sets `inv_o`, and `stat_out` equals `stat_in` unchanged.
- R5: Any other sub-opcode sets `ill_o`, keeps `inv_o` low, and makes `stat_out` equal `stat_in`.
- R6: In single precision, the first specifier is `instr[18:14]` and the second is `instr[4:0]`. An even specifier selects bits 63:32 of its 64-bit pair and an odd one selects bits 31:0. Double precision uses all 64 bits.
- R7: Positive and negative zero compare equal. Infinities order normally against finite values.
- R8: When both operands are negative, the magnitude order is reversed. With differing signs, the negative operand is less.
- R9: Results are registered. `done_o` is high exactly one cycle after each `in_valid`, including back-to-back strobes. `inv_o` and `ill_o` are only high with `done_o`, and never together. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe, one cycle per compare |
| instr | input | 32 | Instruction word (specifiers and sub-opcode) |
| opnd_a | input | 64 | Register pair holding the first operand |
| opnd_b | input | 64 | Register pair holding the second operand |
| stat_in | input | 32 | Current status word |
| stat_out | output | 32 | Updated status word |
| done_o | output | 1 | Result valid pulse |
| inv_o | output | 1 | Invalid-operation exception |
| ill_o | output | 1 | Illegal-instruction flag |

## Verification
The bench targets these cases:
- **Zeros of opposite sign.** A plain bit comparison would report them as greater or less.
- **Two negative operands.** A design that forgets to reverse the magnitude order returns the mirrored code.
- **A NaN under each policy.** A unit that swaps the policies either raises a spurious exception or writes code 3 where the field must stay unchanged.
- **Odd single-precision specifiers.** These are paired with a NaN planted in the unused half of the pair, so a wrong word select shows up as unordered.
- **Back-to-back requests.** A design that drops one strobe shows a missing done.
- **An out-of-group sub-opcode.** This must not disturb the status word.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int OPSEL_LSB = 5;
    localparam int OPSEL_W   = 9;
    localparam int RS1_LSB   = 14;
    localparam int RS2_LSB   = 0;

    localparam logic [OPSEL_W-1:0] OP_QUIET_SP = 9'h051;
    localparam logic [OPSEL_W-1:0] OP_QUIET_DP = 9'h052;
    localparam logic [OPSEL_W-1:0] OP_SIGNL_SP = 9'h055;
    localparam logic [OPSEL_W-1:0] OP_SIGNL_DP = 9'h056;

    typedef enum logic [1:0] {
        CC_EQ = 2'd0,
        CC_LT = 2'd1,
        CC_GT = 2'd2,
        CC_UN = 2'd3
    } fcc_code_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } fcc_state_e;

    typedef struct packed {
        logic legal;
        logic dbl;
        logic signl;
    } fcc_op_t;

endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
    import fcc_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic [IW-1:0] instr,
    output fcc_op_t       op,
    output logic          a_hi,
    output logic          b_hi
);

    logic [OPSEL_W-1:0] opsel;

    assign opsel = instr[OPSEL_LSB +: OPSEL_W];

    // Even specifier names the high word of its pair
    assign a_hi = ~instr[RS1_LSB];
    assign b_hi = ~instr[RS2_LSB];

    always_comb begin
        op = '{legal: 1'b0, dbl: 1'b0, signl: 1'b0};
        case (opsel)
            OP_QUIET_SP: op = '{legal: 1'b1, dbl: 1'b0, signl: 1'b0};
            OP_QUIET_DP: op = '{legal: 1'b1, dbl: 1'b1, signl: 1'b0};
            OP_SIGNL_SP: op = '{legal: 1'b1, dbl: 1'b0, signl: 1'b1};
            OP_SIGNL_DP: op = '{legal: 1'b1, dbl: 1'b1, signl: 1'b1};
            default:     op = '{legal: 1'b0, dbl: 1'b0, signl: 1'b0};
        endcase
    end

endmodule

// File: rtl/fcc_order.sv
module fcc_order
    import fcc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output fcc_code_e             code,
    output logic                  unord
);

    localparam int MAG_W = EXP_W + FRAC_W;

    logic             sgn_a, sgn_b;
    logic [MAG_W-1:0] mag_a, mag_b;
    logic             nan_a, nan_b;
    logic             mag_lt;

    assign sgn_a = a[MAG_W];
    assign sgn_b = b[MAG_W];
    assign mag_a = a[MAG_W-1:0];
    assign mag_b = b[MAG_W-1:0];

    assign nan_a = (&a[MAG_W-1 -: EXP_W]) & (|a[FRAC_W-1:0]);
    assign nan_b = (&b[MAG_W-1 -: EXP_W]) & (|b[FRAC_W-1:0]);
    assign unord = nan_a | nan_b;
    assign mag_lt = mag_a < mag_b;

    always_comb begin
        if (unord)
            code = CC_UN;
        else if (mag_a == '0 && mag_b == '0)
            code = CC_EQ;
        else if (sgn_a != sgn_b)
            code = sgn_a ? CC_LT : CC_GT;
        else if (mag_a == mag_b)
            code = CC_EQ;
        else
            code = (mag_lt ^ sgn_a) ? CC_LT : CC_GT;
    end

endmodule

// File: rtl/fcc_unit.sv
module fcc_unit
    import fcc_pkg::*;
#(
    parameter int IW       = 32,
    parameter int DW       = 64,
    parameter int STAT_W   = 32,
    parameter int CC_LSB   = 10,
    parameter int S_EXP_W  = 8,
    parameter int D_EXP_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [IW-1:0]     instr,
    input  logic [DW-1:0]     opnd_a,
    input  logic [DW-1:0]     opnd_b,
    input  logic [STAT_W-1:0] stat_in,
    output logic [STAT_W-1:0] stat_out,
    output logic              done_o,
    output logic              inv_o,
    output logic              ill_o
);

    localparam int SW       = DW / 2;
    localparam int S_FRAC_W = SW - 1 - S_EXP_W;
    localparam int D_FRAC_W = DW - 1 - D_EXP_W;

    fcc_op_t      op;
    logic         a_hi, b_hi;
    logic [SW-1:0] a_s, b_s;
    fcc_code_e    code_s, code_d, code_sel;
    logic         nan_s, nan_d, nan_sel;
    logic [STAT_W-1:0] merged;

    fcc_state_e   state_q, state_d;
    logic [STAT_W-1:0] stat_q;
    logic         inv_q, ill_q;

    fcc_decode #(.IW(IW)) u_dec (
        .instr (instr),
        .op    (op),
        .a_hi  (a_hi),
        .b_hi  (b_hi)
    );

    assign a_s = a_hi ? opnd_a[DW-1:SW] : opnd_a[SW-1:0];
    assign b_s = b_hi ? opnd_b[DW-1:SW] : opnd_b[SW-1:0];

    fcc_order #(.EXP_W(S_EXP_W), .FRAC_W(S_FRAC_W)) u_ord_sp (
        .a     (a_s),
        .b     (b_s),
        .code  (code_s),
        .unord (nan_s)
    );

    fcc_order #(.EXP_W(D_EXP_W), .FRAC_W(D_FRAC_W)) u_ord_dp (
        .a     (opnd_a),
        .b     (opnd_b),
        .code  (code_d),
        .unord (nan_d)
    );

    assign code_sel = op.dbl ? code_d : code_s;
    assign nan_sel  = op.dbl ? nan_d  : nan_s;

    always_comb begin
        merged = stat_in;
        merged[CC_LSB +: 2] = code_sel;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            inv_q  <= 1'b0;
            ill_q  <= 1'b0;
        end else begin
            inv_q <= 1'b0;
            ill_q <= 1'b0;
            if (in_valid) begin
                if (!op.legal) begin
                    ill_q  <= 1'b1;
                    stat_q <= stat_in;
                end else if (op.signl && nan_sel) begin
                    inv_q  <= 1'b1;
                    stat_q <= stat_in;
                end else begin
                    stat_q <= merged;
                end
            end
        end
    end

    assign stat_out = stat_q;
    assign done_o   = (state_q == ST_REPORT);
    assign inv_o    = inv_q;
    assign ill_o    = ill_q;

    // R9
    done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done_o);

    // R9
    done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(in_valid));

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(inv_o && ill_o) && ((inv_o || ill_o) -> done_o));

    // R4
    signal_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op.legal && op.signl && nan_sel) |=> (inv_o && stat_out == $past(stat_in)));

    // R5
    illegal_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ill_o |-> (stat_out == $past(stat_in)));

    // R2
    other_bits_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (stat_out[STAT_W-1:CC_LSB+2] == $past(stat_in[STAT_W-1:CC_LSB+2])
                      && stat_out[CC_LSB-1:0] == $past(stat_in[CC_LSB-1:0])));

endmodule

// File: tb/test_fcc_unit.sv
module test_fcc_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] stat;
        logic        inv;
        logic        ill;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic [31:0] stat_in = '0;
    logic [31:0] stat_out;
    logic        done_o, inv_o, ill_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcc_unit i_fcc_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .instr    (instr),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .stat_in  (stat_in),
        .stat_out (stat_out),
        .done_o   (done_o),
        .inv_o    (inv_o),
        .ill_o    (ill_o)
    );

    function automatic bit nan_s(input logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic bit nan_d(input logic [63:0] v);
        return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
    endfunction

    function automatic real s2r(input logic [31:0] v);
        real r;
        if (v[30:23] == 8'h00)
            r = real'(v[22:0]) * (2.0 ** (-149));
        else if (v[30:23] == 8'hFF)
            r = $bitstoreal(64'h7FF0_0000_0000_0000);
        else
            r = $bitstoreal({1'b0, 11'(v[30:23] - 8'd127 + 11'd1023), v[22:0], 29'b0});
        return v[31] ? -r : r;
    endfunction

    // Reference model built from the requirements
    function automatic exp_t model(input logic [31:0] ins, input logic [63:0] a,
                                   input logic [63:0] b, input logic [31:0] st, input string tag);
        exp_t e;
        logic [8:0] op;
        bit dbl, sig, un;
        real ra, rb;
        logic [1:0] cc;
        logic [31:0] wa, wb;
        e.stat = st; e.inv = 1'b0; e.ill = 1'b0; e.tag = tag;
        op = ins[13:5];
        if (op != 9'h51 && op != 9'h52 && op != 9'h55 && op != 9'h56) begin
            e.ill = 1'b1;
            return e;
        end
        dbl = (op == 9'h52 || op == 9'h56);
        sig = (op == 9'h55 || op == 9'h56);
        if (dbl) begin
            un = nan_d(a) || nan_d(b);
            ra = un ? 0.0 : $bitstoreal(a);
            rb = un ? 0.0 : $bitstoreal(b);
        end else begin
            wa = ins[14] ? a[31:0] : a[63:32];
            wb = ins[0]  ? b[31:0] : b[63:32];
            un = nan_s(wa) || nan_s(wb);
            ra = un ? 0.0 : s2r(wa);
            rb = un ? 0.0 : s2r(wb);
        end
        if (un && sig) begin
            e.inv = 1'b1;
            return e;
        end
        if (un)           cc = 2'd3;
        else if (ra == rb) cc = 2'd0;
        else if (ra < rb)  cc = 2'd1;
        else               cc = 2'd2;
        e.stat[11:10] = cc;
        return e;
    endfunction

    function automatic logic [31:0] mk(input logic [8:0] op, input logic [4:0] r1, input logic [4:0] r2);
        return {13'h15A5, r1, op, r2};
    endfunction

    // Driver: holds in_valid for one cycle per call; back-to-back if called repeatedly
    task automatic drive(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                         input logic [31:0] st, input string tag);
        @(negedge clk);
        instr = ins; opnd_a = a; opnd_b = b; stat_in = st; in_valid = 1'b1;
        sb.push_back(model(ins, a, b, st, tag));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            instr = '0; opnd_a = '0; opnd_b = '0; stat_in = '0;
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !finished && done_o) begin
            exp_t e;
            n_vec++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R9 spurious done: actual done=1 expected done=0");
            end else begin
                e = sb.pop_front();
                if (stat_out !== e.stat || inv_o !== e.inv || ill_o !== e.ill) begin
                    n_bad++;
                    $display("FAIL %s: actual stat=%h inv=%b ill=%b expected stat=%h inv=%b ill=%b",
                             e.tag, stat_out, inv_o, ill_o, e.stat, e.inv, e.ill);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        // R9 reset state
        if (stat_out !== 32'h0 || done_o !== 1'b0 || inv_o !== 1'b0 || ill_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 reset: actual stat=%h done=%b inv=%b ill=%b expected all zero",
                     stat_out, done_o, inv_o, ill_o);
        end
        rst_n = 1'b1;
        idle(1);

        // R2 less / greater / equal, other status bits kept
        drive(mk(9'h51, 5'd2, 5'd4), {32'h3F80_0000, 32'h0}, {32'h4000_0000, 32'h0}, 32'hFFFF_F3FF, "R2 lt");
        idle(1);
        drive(mk(9'h51, 5'd2, 5'd4), {32'h4000_0000, 32'h0}, {32'h3F80_0000, 32'h0}, 32'hA5A5_A5A5, "R2 gt");
        idle(1);
        drive(mk(9'h51, 5'd2, 5'd4), {32'h4000_0000, 32'h0}, {32'h4000_0000, 32'h0}, 32'h0000_0C00, "R2 eq");
        idle(1);
        // R7 signed zeros
        drive(mk(9'h51, 5'd0, 5'd6), {32'h0000_0000, 32'h0}, {32'h8000_0000, 32'h0}, 32'h1234_5678, "R7 zeros");
        idle(1);
        // R8 both negative
        drive(mk(9'h51, 5'd0, 5'd6), {32'hBF80_0000, 32'h0}, {32'hC000_0000, 32'h0}, 32'h0, "R8 neg");
        idle(1);
        // R8 differing signs
        drive(mk(9'h51, 5'd0, 5'd6), {32'hBF80_0000, 32'h0}, {32'h3F80_0000, 32'h0}, 32'h0, "R8 mixed");
        idle(1);
        // R7 infinities
        drive(mk(9'h51, 5'd8, 5'd10), {32'hFF80_0000, 32'h0}, {32'h7F7F_FFFF, 32'h0}, 32'h0, "R7 -inf");
        idle(1);
        drive(mk(9'h51, 5'd8, 5'd10), {32'h7F80_0000, 32'h0}, {32'h7F7F_FFFF, 32'h0}, 32'h0, "R7 +inf");
        idle(1);
        // R3 quiet NaN
        drive(mk(9'h51, 5'd2, 5'd4), {32'h7FC0_0000, 32'h0}, {32'h3F80_0000, 32'h0}, 32'h0000_0400, "R3 qnan");
        idle(1);
        // R4 signalling NaN
        drive(mk(9'h55, 5'd2, 5'd4), {32'h3F80_0000, 32'h0}, {32'h7FC0_0001, 32'h0}, 32'hDEAD_BEEF, "R4 snan");
        idle(1);
        // R1 signalling compare without NaN behaves normally
        drive(mk(9'h55, 5'd2, 5'd4), {32'h4000_0000, 32'h0}, {32'h3F80_0000, 32'h0}, 32'h0, "R1 sig ok");
        idle(1);
        // R1 R6 doubles
        drive(mk(9'h52, 5'd2, 5'd4), 64'h3FF8_0000_0000_0000, 64'h3FF4_0000_0000_0000, 32'h0, "R1 R6 dbl gt");
        idle(1);
        drive(mk(9'h52, 5'd2, 5'd4), 64'hFFF0_0000_0000_0000, 64'h3FF4_0000_0000_0000, 32'hFFFF_FFFF, "R1 dbl -inf");
        idle(1);
        drive(mk(9'h52, 5'd2, 5'd4), 64'h7FF8_0000_0000_0001, 64'h3FF4_0000_0000_0000, 32'h0, "R3 dbl qnan");
        idle(1);
        drive(mk(9'h56, 5'd2, 5'd4), 64'h3FF4_0000_0000_0000, 64'h7FF0_0000_0000_0010, 32'h5555_5555, "R4 dbl snan");
        idle(1);
        drive(mk(9'h56, 5'd2, 5'd4), 64'hBFF8_0000_0000_0000, 64'hBFF4_0000_0000_0000, 32'h0, "R8 dbl neg");
        idle(1);
        // R6 odd specifiers select low words; NaN parked in the high words
        drive(mk(9'h51, 5'd3, 5'd5), {32'h7FC0_0000, 32'h3F80_0000}, {32'h7FC0_0000, 32'h4000_0000}, 32'h0, "R6 odd");
        idle(1);
        drive(mk(9'h51, 5'd3, 5'd4), {32'h7FC0_0000, 32'h4000_0000}, {32'h3F80_0000, 32'h7FC0_0000}, 32'h0, "R6 mixed");
        idle(1);
        // R5 illegal sub-opcodes
        drive(mk(9'h053, 5'd2, 5'd4), {32'h7FC0_0000, 32'h0}, {32'h0, 32'h0}, 32'hCAFE_F00D, "R5 ill 53");
        idle(1);
        drive(mk(9'h151, 5'd2, 5'd4), {32'h3F80_0000, 32'h0}, {32'h0, 32'h0}, 32'h0000_0800, "R5 ill 151");
        idle(1);
        // R9 back-to-back requests
        drive(mk(9'h51, 5'd2, 5'd4), {32'h3F80_0000, 32'h0}, {32'h4000_0000, 32'h0}, 32'h1, "R9 b2b 1");
        drive(mk(9'h51, 5'd2, 5'd4), {32'h4000_0000, 32'h0}, {32'h3F80_0000, 32'h0}, 32'h2, "R9 b2b 2");
        drive(mk(9'h55, 5'd2, 5'd4), {32'h7FC0_0000, 32'h0}, {32'h3F80_0000, 32'h0}, 32'h3, "R9 b2b 3");
        idle(4);

        // R9 no result pending and done low when idle
        n_vec++;
        if (sb.size() != 0 || done_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R9 idle: actual pending=%0d done=%b expected pending=0 done=0", sb.size(), done_o);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule